// File: doc/BRIEF.md
# Retention-binned row refresh scheduler

This block sits in a DRAM controller and decides, one candidate row at a time, whether a row needs a row-activate refresh. A rate prescaler divides the core clock into candidate slots. A candidate counter walks every row of every bank, and the bank field changes fastest, so consecutive candidates fall on different banks. A period counter records how many full sweeps of the candidate space have passed. Each candidate is looked up in a set of retention bins. Each bin is a small Bloom filter, and the bin with the shortest interval that claims the row sets how often the row is refreshed. A row that no bin claims falls back to the longest, default interval. Refreshes of the longer-interval rows are spread over the sweeps by matching low row-address bits against low period-counter bits, so no single sweep carries a burst.

Rows that retain data poorly are loaded into the bins by a plain insertion port while a load-enable input is held. During that time every candidate is refreshed. The terminal count of the prescaler is programmable, and a single hot-mode input halves the slot period so that all rows are refreshed twice as often. Refresh requests leave on a valid/ready stream toward the command scheduler. While valid is high and ready is low, the request and its bank and row fields hold still. No new candidate slot is consumed until the request is taken, so a required refresh is never lost. Ready may be high or low at any time, and valid does not wait for ready.

Top module: `retention_refresh_sched`

## Requirements
- R1: During and after reset, req_valid is low. The candidate index and the period counter start at 0. The first request, candidate 0, appears after exactly L+1 rising edges following the release of reset (L is defined in R9).
- R2: The candidate index c has BANK_W+ROW_W bits. req_bank carries c[BANK_W-1:0] and req_row carries c[BANK_W+ROW_W-1:BANK_W]. The index steps by one per candidate slot and wraps to 0, so two consecutive candidates never share a bank.
- R3: The PER_W-bit period counter increments once each time the candidate index wraps from all ones to 0. It wraps modulo 2^PER_W.
- R4: A candidate claimed by bin 0 (the shortest interval) is refreshed on every visit.
- R5: A candidate whose lowest claiming bin is b ≥ 1 is refreshed only when row[b-1:0] equals period[b-1:0]. With PER_W=2, bin 1 refreshes a row when the row LSB equals the period LSB.
- R6: A candidate claimed by no bin is refreshed only when row[PER_W-1:0] equals the whole period counter. This gives an interval of 2^PER_W sweeps.
- R7: When several bins claim a candidate, the bin with the lowest index decides.
- R8: Each bin is a Bloom filter of 2^FILT_W bits that starts cleared at reset. Hash j of key k uses the odd constant C_j = ((107·j + 157) mod 2^KEY_W) | 1. Its bit position is bits [KEY_W-1 : KEY_W-FILT_W] of (k·C_j mod 2^KEY_W), for j = 0..NHASH-1. An insertion (ins_en high, ins_bin = b, ins_key = k, with k in the same {row, bank} format as c) sets all NHASH positions of k in bin b. A key is claimed by a bin when all NHASH of its positions are set.
- R9: A candidate slot occurs every L+1 cycles, where L = scale_tc when scale_hot is 0 and L = scale_tc >> 1 when scale_hot is 1 (an odd scale_tc gives exactly half the period).
- R10: While req_valid is high and req_ready is low, req_valid, req_bank and req_row hold their values and the candidate index does not advance. Every refresh that is decided is delivered in candidate order.
- R11: While load_en is high, every candidate is refreshed whatever the bins hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scale_tc | input | PRE_W | Prescaler terminal count; the slot period is terminal+1 cycles |
| scale_hot | input | 1 | High-temperature mode; halves the terminal count |
| load_en | input | 1 | Bins not yet valid; refresh every candidate |
| ins_en | input | 1 | Insert ins_key into bin ins_bin this cycle |
| ins_bin | input | BIN_IW | Target bin of an insertion, 0 being the shortest interval |
| ins_key | input | BANK_W+ROW_W | Row key to insert, formatted {row, bank} |
| req_valid | output | 1 | Refresh request present |
| req_ready | input | 1 | Command scheduler takes the request |
| req_bank | output | BANK_W | Bank of the row to activate |
| req_row | output | ROW_W | Row address to activate |

## Verification
The two functions that can fall in the same cycle are the acceptance of a pending request and the start of the next candidate slot. When the prescaler has already reached its terminal count while blocked, ready going high both retires the old request and loads the next one on the same edge. Random ready at 70 percent, with a prescaler period of two cycles, provokes this collision many times. A bench model walks its own candidate index, period counter and copies of the Bloom filters, and each accepted request must be the next candidate that the model judges needs a refresh. A dropped, duplicated or reordered refresh therefore shows up at once. A second overlap, bin insertions while a request is held, is checked by requiring the held fields to stay unchanged throughout.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // Odd multiplier for hash j over a w-bit key.
  function automatic int unsigned mul_const(input int unsigned j, input int unsigned w);
    int unsigned v;
    v = (j * 107 + 157) & ((32'd1 << w) - 1);
    return v | 32'd1;
  endfunction

endpackage

// File: rtl/rrs_prescaler.sv
module rrs_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] tc,
  input  logic             hot,
  input  logic             hold,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;
  logic             at_end;

  assign limit  = hot ? (tc >> 1) : tc;
  assign at_end = (cnt_q >= limit);
  assign tick   = at_end && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (at_end) begin
      if (!hold) cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rrs_cand_counter.sv
module rrs_cand_counter #(
  parameter int KEY_W = 8,
  parameter int PER_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [KEY_W-1:0] cand,
  output logic [PER_W-1:0] per
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand <= '0;
      per  <= '0;
    end else if (advance) begin
      cand <= cand + 1'b1;
      if (&cand) per <= per + 1'b1;
    end
  end
endmodule

// File: rtl/rrs_bloom_bin.sv
module rrs_bloom_bin #(
  parameter int KEY_W  = 8,
  parameter int FILT_W = 6,
  parameter int NHASH  = 2,
  localparam int M     = 1 << FILT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [KEY_W-1:0] ins_key,
  input  logic [KEY_W-1:0] probe_key,
  output logic             hit
);
  logic [M-1:0] bits_q;
  logic [M-1:0] ins_mask;

  function automatic logic [FILT_W-1:0] slot(input logic [KEY_W-1:0] k, input int unsigned j);
    logic [KEY_W-1:0] p;
    p = k * KEY_W'(rrs_pkg::mul_const(j, KEY_W));
    return FILT_W'(p >> (KEY_W - FILT_W));
  endfunction

  always_comb begin
    ins_mask = '0;
    hit      = 1'b1;
    for (int j = 0; j < NHASH; j++) begin
      ins_mask[slot(ins_key, j)] = 1'b1;
      hit = hit & bits_q[slot(probe_key, j)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bits_q <= '0;
    else if (ins_en) bits_q <= bits_q | ins_mask;
  end
endmodule

// File: rtl/rrs_decide.sv
module rrs_decide #(
  parameter int PER_W = 2
) (
  input  logic [PER_W-1:0] row_lsb,
  input  logic [PER_W-1:0] per,
  input  logic [PER_W-1:0] hits,
  input  logic             load_en,
  output logic             need
);
  logic [PER_W-1:0] mask;

  always_comb begin
    // Default interval compares every period bit; the lowest claiming bin
    // narrows the comparison to its own count of low bits (bin 0: none).
    mask = '1;
    for (int b = PER_W - 1; b >= 0; b--) begin
      if (hits[b]) mask = PER_W'((1 << b) - 1);
    end
    need = load_en || (((row_lsb ^ per) & mask) == '0);
  end
endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched #(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 5,
  parameter int PER_W   = 2,
  parameter int FILT_W  = 6,
  parameter int NHASH   = 2,
  parameter int PRE_W   = 8,
  localparam int KEY_W  = BANK_W + ROW_W,
  localparam int BIN_IW = (PER_W > 1) ? $clog2(PER_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  scale_tc,
  input  logic              scale_hot,
  input  logic              load_en,
  input  logic              ins_en,
  input  logic [BIN_IW-1:0] ins_bin,
  input  logic [KEY_W-1:0]  ins_key,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row
);
  logic             slot_tick;
  logic             hold;
  logic             need;
  logic [KEY_W-1:0] cand;
  logic [PER_W-1:0] per;
  logic [PER_W-1:0] bin_hits;

  assign hold = req_valid && !req_ready;

  rrs_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tc(scale_tc), .hot(scale_hot),
    .hold(hold), .tick(slot_tick)
  );

  rrs_cand_counter #(.KEY_W(KEY_W), .PER_W(PER_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .advance(slot_tick), .cand(cand), .per(per)
  );

  for (genvar b = 0; b < PER_W; b++) begin : g_bin
    rrs_bloom_bin #(.KEY_W(KEY_W), .FILT_W(FILT_W), .NHASH(NHASH)) u_bin (
      .clk(clk), .rst_n(rst_n),
      .ins_en(ins_en && (ins_bin == BIN_IW'(b))),
      .ins_key(ins_key), .probe_key(cand), .hit(bin_hits[b])
    );
  end

  rrs_decide #(.PER_W(PER_W)) u_dec (
    .row_lsb(cand[BANK_W +: PER_W]), .per(per), .hits(bin_hits),
    .load_en(load_en), .need(need)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_bank  <= '0;
      req_row   <= '0;
    end else if (slot_tick && need) begin
      req_valid <= 1'b1;
      req_bank  <= cand[BANK_W-1:0];
      req_row   <= cand[KEY_W-1:BANK_W];
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 5,
  parameter int PER_W  = 2,
  localparam int KEY_W = BANK_W + ROW_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic [KEY_W-1:0]  cand,
  input logic [PER_W-1:0]  per,
  input logic              tick,
  input logic [PER_W-1:0]  hits,
  input logic              load_en
);
  p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_bank) && $stable(req_row));

  p_no_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(cand));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cand != $past(cand) |-> cand == $past(cand) + 1'b1);

  p_period_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per != $past(per) |-> &$past(cand));

  p_load_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick && load_en |=> req_valid && ({req_row, req_bank} == $past(cand)));

  p_bin0_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && hits[0] |=> req_valid && ({req_row, req_bank} == $past(cand)));

  p_new_on_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(tick));
endmodule

bind retention_refresh_sched rrs_checker #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .PER_W(PER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .req_row(req_row), .cand(cand), .per(per),
  .tick(slot_tick), .hits(bin_hits), .load_en(load_en)
);

// File: tb/tb_retention_refresh_sched.sv
module tb_retention_refresh_sched;
  localparam int BANK_W = 3, ROW_W = 5, PER_W = 2, FILT_W = 6, NHASH = 2, PRE_W = 8;
  localparam int KEY_W = BANK_W + ROW_W;
  localparam int NCAND = 1 << KEY_W;
  localparam int M = 1 << FILT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PRE_W-1:0] scale_tc = '0;
  logic scale_hot = 1'b0, load_en = 1'b1, ins_en = 1'b0;
  logic [0:0] ins_bin = '0;
  logic [KEY_W-1:0] ins_key = '0;
  logic req_valid, req_ready = 1'b0;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0] req_row;

  retention_refresh_sched #(.BANK_W(BANK_W), .ROW_W(ROW_W), .PER_W(PER_W),
    .FILT_W(FILT_W), .NHASH(NHASH), .PRE_W(PRE_W)) dut (
    .clk(clk), .rst_n(rst_n), .scale_tc(scale_tc), .scale_hot(scale_hot),
    .load_en(load_en), .ins_en(ins_en), .ins_bin(ins_bin), .ins_key(ins_key),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row));

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0, xfers = 0;
  bit done = 1'b0;
  bit [M-1:0] mf [PER_W];
  int mc, mper;
  bit mload;
  int exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8 hash model
  function automatic int hpos(input int key, input int j);
    int c, p;
    c = ((j * 107 + 157) % 256) | 1;
    p = (key * c) % 256;
    return p / 4;
  endfunction

  function automatic bit mhit(input int b, input int key);
    for (int j = 0; j < NHASH; j++) if (!mf[b][hpos(key, j)]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit mneed(input int c, input int per, output string tag);
    int row;
    bit h0, h1;
    row = c / 8;
    h0 = mhit(0, c);
    h1 = mhit(1, c);
    if (mload) begin tag = "R11"; return 1'b1; end
    if (h0) begin tag = h1 ? "R7,R8" : "R4,R8"; return 1'b1; end
    if (h1) begin tag = "R5,R8"; return (row % 2) == (per % 2); end
    tag = "R6,R3";
    return (row % 4) == per;
  endfunction

  task automatic next_expected(output int c, output string tag);
    bit nd;
    for (int guard = 0; guard < 4 * NCAND; guard++) begin
      c = mc;
      nd = mneed(mc, mper, tag);
      mc = (mc + 1) % NCAND;
      if (mc == 0) mper = (mper + 1) % 4;  // R3 period step on wrap
      if (nd) return;
    end
    c = -1;
    tag = "model";
  endtask

  task automatic model_reset();
    mc = 0; mper = 0; mf[0] = '0; mf[1] = '0; mload = load_en;
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic run_stream(input int ncyc, input int pct, input int gap);
    int last, nx, s_key, a, e, pbank;
    string t;
    bit was_stall;
    last = -1; nx = 0; was_stall = 1'b0; s_key = 0; pbank = -1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (was_stall) check(req_valid && ({req_row, req_bank} == s_key), "R10", {req_row, req_bank}, s_key);
      req_ready = ($urandom_range(99) < pct);
      if (req_valid && req_ready) begin
        a = {req_row, req_bank};
        if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
        else next_expected(e, t);
        check(a == e, t, a, e);
        if (gap > 0 && nx >= 1) check(int'(req_bank) != pbank, "R2", req_bank, pbank);
        if (gap > 0 && nx >= 2) check(i - last == gap, "R9", i - last, gap);
        last = i; nx++; xfers++; pbank = req_bank;
      end
      was_stall = req_valid && !req_ready;
      s_key = {req_row, req_bank};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int e, k, skey;
    string t;
    void'($urandom(32'h5EED_1234));
    // Phase A: load mode, reset timing, slot period, striping
    load_en = 1'b1; scale_tc = 8'd3; scale_hot = 1'b0; req_ready = 1'b0;
    do_reset();
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      check(req_valid == (n == 4), "R1", req_valid, n == 4);
    end
    check({req_row, req_bank} == 0, "R1", {req_row, req_bank}, 0);
    run_stream(400, 100, 4);
    scale_hot = 1'b1;
    run_stream(200, 100, 2);
    check(xfers > 100, "R9", xfers, 101);

    // Phase B: fill bins under back-pressure, then binned refresh with random ready
    load_en = 1'b1; scale_tc = 8'd1; scale_hot = 1'b0; req_ready = 1'b0;
    do_reset();
    for (int n = 0; n < 10 && !req_valid; n++) @(negedge clk);
    check(req_valid, "R11", req_valid, 1);
    next_expected(e, t);
    exp_q.push_back(e); tag_q.push_back(t);
    skey = {req_row, req_bank};
    mload = 1'b0; load_en = 1'b0;
    for (int n = 0; n < 22; n++) begin
      @(negedge clk);
      check(req_valid && ({req_row, req_bank} == skey), "R10", {req_row, req_bank}, skey);
      if (n == 0 || n == 1) k = 77;  // R7: same key in both bins
      else k = $urandom_range(NCAND - 1);
      ins_en = 1'b1;
      ins_bin = (n == 1 || n > 8) ? 1'b1 : 1'b0;
      ins_key = KEY_W'(k);
      for (int j = 0; j < NHASH; j++) mf[ins_bin][hpos(k, j)] = 1'b1;
    end
    @(negedge clk);
    ins_en = 1'b0;
    check(req_valid && ({req_row, req_bank} == skey), "R10", {req_row, req_bank}, skey);
    xfers = 0;
    run_stream(9000, 70, 0);
    check(xfers > 500, "R6", xfers, 501);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule